// File: doc/BRIEF.md
# DRAM Extended Mode Register Programming Sequencer

This block sits in a memory controller and rewrites a graphics DRAM's extended mode register on request. An accepted request starts a fixed command sequence on the command bus. First comes a precharge of all banks. After the row-precharge gap the block issues the extended-mode-register write, carrying the packed configuration word. It then holds the bus idle for the mode-register gap. When the request changes the output driver impedance to one of the fixed settings, a burst of evenly spaced auto-refresh commands follows before the bus is released.

The write-recovery field in the word is not supplied directly. The block computes it from the write-recovery time and the clock period, both given in picoseconds. It checks the result against the legal range of the selected mapping and rejects requests that fall outside that range. A separate guard drives a read-permit output. The guard restarts a fixed lock window each time the DLL is switched on by a register write, and again at every exit from self-refresh. The controller may issue reads only while the permit is high.

The sequencer steps through the states IDLE, PREALL, RP_WAIT, EMRS, MRD_WAIT, AREF and RFC_WAIT. The transitions are: IDLE→PREALL on an accepted request; PREALL→RP_WAIT, or PREALL→EMRS when the gap is one cycle; RP_WAIT→EMRS when the count expires; EMRS→MRD_WAIT, or EMRS→AREF/IDLE when the gap is one cycle; MRD_WAIT→AREF if a refresh burst is due, otherwise MRD_WAIT→IDLE; AREF→RFC_WAIT, or AREF→AREF/IDLE when the gap is one cycle; RFC_WAIT→AREF while refreshes remain, otherwise RFC_WAIT→IDLE. A single down-counter times every wait state.

Top module: `emrs_seq`

## Requirements
- R1: The `cmd` output uses these codes: NOP=0, PREALL=1, EMRS=2, AREF=3. In every cycle without a command, `cmd` is NOP and `addr` and `ba` are zero. Out of reset, `cmd`=NOP, and `busy`, `rd_ok` and `wr_err` are all 0.
- R2: When a legal request is sampled at a clock edge, PREALL appears in the cycle that follows. EMRS appears exactly max(`trp_cyc`,1) cycles after PREALL.
- R3: `busy` rises in the PREALL cycle. When no refresh burst is due, the first cycle with `busy` low is exactly max(`tmrd_cyc`,1) cycles after the EMRS cycle.
- R4: The write-recovery value WR is the smallest whole number with WR×`tck_time` ≥ `twr_time`, which is the time ratio rounded up.
- R5: With `hs_map`=1, WR must lie in 7..13 and the field code is WR−7. With `hs_map`=0, WR must lie in 4..11 and the code is WR−4. A request with WR out of range, or with `tck_time`=0, issues no command, leaves `busy` low, and makes `wr_err` high for exactly the one cycle after the request.
- R6: During EMRS, `ba`=01 and `addr` carries the configuration word. The bit positions are: A1:A0 = impedance select, A3:A2 = termination select, A4 = code bit 0, A5 = code bit 1, A6 = DLL off, A7 = code bit 2. All other bits are 0. Outside EMRS, `addr` is 0.
- R7: A refresh burst is due when the request's impedance select is nonzero (1=30, 2=40, 3=45 ohm) and differs from the last accepted select (0 after reset). The burst has 16 AREF commands. The first AREF comes max(`tmrd_cyc`,1) cycles after EMRS. Consecutive AREFs are G = max(`trfc_cyc`,`tko_cyc`,1) cycles apart. `busy` falls G cycles after the last AREF.
- R8: A request whose impedance select is 0, or equals the last accepted select, produces no AREF.
- R9: After an EMRS with A6=0, `rd_ok` is low from the next cycle. It rises exactly DLL_LOCK cycles after the EMRS cycle.
- R10: A one-cycle pulse on `sref_exit` restarts the same window: `rd_ok` rises exactly DLL_LOCK cycles after the pulse cycle.
- R11: After an EMRS with A6=1, `rd_ok` is low from the next cycle and stays low until the next enabling event.
- R12: A request that arrives while `busy` is high is ignored. The fields and mapping are captured when the request is accepted, so later changes to the inputs do not alter the word that is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe for a reprogramming sequence |
| hs_map | input | 1 | 1 = high-speed write-recovery mapping, 0 = mid-range mapping |
| imp_sel | input | 2 | Driver impedance select: 0 = auto calibration, 1/2/3 = 30/40/45 ohm |
| term_sel | input | 2 | Termination select code |
| dll_off | input | 1 | 1 = disable the DLL |
| twr_time | input | TW | Write-recovery time in picoseconds |
| tck_time | input | TW | Clock period in picoseconds |
| trp_cyc | input | CW | Precharge-to-register-write gap in cycles |
| tmrd_cyc | input | CW | Register-write gap in cycles |
| trfc_cyc | input | CW | Refresh cycle time in cycles |
| tko_cyc | input | CW | Bus-quiet time after each refresh, in cycles |
| sref_exit | input | 1 | One-cycle pulse marking an exit from self-refresh |
| cmd | output | 3 | Command code |
| ba | output | 2 | Bank address |
| addr | output | AW | Address bus |
| busy | output | 1 | Sequence in progress |
| rd_ok | output | 1 | Read permit |
| wr_err | output | 1 | One-cycle pulse on a rejected request |

## Verification
The bench builds the block with DLL_LOCK=50 instead of 1000. This brings both edges of each read-permit window into reach within a few dozen cycles of every register write and every self-refresh exit. It keeps N_AREF=16, so each full refresh burst is compared command by command against its expected spacing, and it uses TW=16. That width makes realistic picosecond pairs possible, including exact multiples, values that need rounding up, and both ends of each mapping's range.

// File: rtl/emrs_pkg.sv
package emrs_pkg;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_PREALL = 3'd1,
        CMD_EMRS   = 3'd2,
        CMD_AREF   = 3'd3
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREALL,
        S_RP_WAIT,
        S_EMRS,
        S_MRD_WAIT,
        S_AREF,
        S_RFC_WAIT
    } seq_state_e;

    // bank address that selects the extended register
    localparam logic [1:0] EMR_BANK = 2'b01;

    // word layout: positions decoded by the memory device
    localparam int POS_IMP  = 0;
    localparam int POS_TERM = 2;
    localparam int POS_WR0  = 4;
    localparam int POS_WR1  = 5;
    localparam int POS_DLL  = 6;
    localparam int POS_WR2  = 7;

    // legal write-recovery windows per mapping
    localparam int HS_WR_LO = 7;
    localparam int HS_WR_HI = 13;
    localparam int MR_WR_LO = 4;
    localparam int MR_WR_HI = 11;

endpackage

// File: rtl/emrs_wr_calc.sv
module emrs_wr_calc
    import emrs_pkg::*;
#(
    parameter int TW     = 16,
    parameter int WR_MAX = 15,
    localparam int WRW   = $clog2(WR_MAX + 1)
) (
    input  logic [TW-1:0]  twr_time,
    input  logic [TW-1:0]  tck_time,
    input  logic           hs_map,
    output logic [WRW-1:0] wr_cyc,
    output logic [2:0]     wr_code,
    output logic           wr_ok
);
    localparam int PW = TW + WRW;

    logic [WRW-1:0] wr_v;
    logic [WRW-1:0] lo;
    logic [WRW-1:0] hi;
    logic [WRW-1:0] diff;

    // smallest multiple count that covers the recovery time
    always_comb begin
        wr_v = '0;
        if (tck_time != '0) begin
            for (int n = WR_MAX; n >= 1; n--) begin
                if (PW'(tck_time) * PW'(n) >= PW'(twr_time)) begin
                    wr_v = WRW'(n);
                end
            end
        end
    end

    always_comb begin
        lo      = hs_map ? WRW'(HS_WR_LO) : WRW'(MR_WR_LO);
        hi      = hs_map ? WRW'(HS_WR_HI) : WRW'(MR_WR_HI);
        wr_ok   = (wr_v != '0) && (wr_v >= lo) && (wr_v <= hi);
        diff    = wr_v - lo;
        wr_code = diff[2:0];
        wr_cyc  = wr_v;
    end

endmodule

// File: rtl/emrs_dll_guard.sv
module emrs_dll_guard #(
    parameter int DLL_LOCK = 1000,
    localparam int LW      = $clog2(DLL_LOCK + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_evt,
    input  logic dis_evt,
    output logic rd_ok
);
    logic          dll_on;
    logic [LW-1:0] lock_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_on   <= 1'b0;
            lock_cnt <= '0;
        end else if (dis_evt) begin
            dll_on   <= 1'b0;
            lock_cnt <= '0;
        end else if (en_evt) begin
            dll_on   <= 1'b1;
            lock_cnt <= LW'(DLL_LOCK - 1);
        end else if (lock_cnt != '0) begin
            lock_cnt <= lock_cnt - LW'(1);
        end
    end

    assign rd_ok = dll_on && (lock_cnt == '0);

endmodule

// File: rtl/emrs_seq_fsm.sv
module emrs_seq_fsm
    import emrs_pkg::*;
#(
    parameter int CW     = 8,
    parameter int N_AREF = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr_ok,
    input  logic          imp_chg,
    input  logic [CW-1:0] trp_cyc,
    input  logic [CW-1:0] tmrd_cyc,
    input  logic [CW-1:0] trfc_cyc,
    input  logic [CW-1:0] tko_cyc,
    output cmd_e          cmd,
    output logic          busy,
    output logic          accept,
    output logic          err_pulse
);
    localparam int RW = $clog2(N_AREF + 1);
    localparam logic [CW-1:0] ONE = CW'(1);

    seq_state_e    state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt;
    logic [RW-1:0] ref_n, nxt_ref;
    logic          burst_q, nxt_burst;
    logic          reject;

    logic [CW-1:0] g_rp, g_mrd, g_ref, ref_raw;
    seq_state_e    after_mrd, after_ref, after_wait;

    function automatic logic [CW-1:0] floor1(input logic [CW-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    always_comb begin
        ref_raw = (trfc_cyc > tko_cyc) ? trfc_cyc : tko_cyc;
        g_rp    = floor1(trp_cyc);
        g_mrd   = floor1(tmrd_cyc);
        g_ref   = floor1(ref_raw);
        accept  = (state == S_IDLE) && req && wr_ok;
        reject  = (state == S_IDLE) && req && !wr_ok;
    end

    always_comb begin
        after_mrd  = burst_q ? S_AREF : S_IDLE;
        after_ref  = (ref_n == RW'(N_AREF - 1)) ? S_IDLE : S_AREF;
        after_wait = (ref_n == RW'(N_AREF)) ? S_IDLE : S_AREF;
    end

    // next-state and wait-count logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_ref   = ref_n;
        nxt_burst = burst_q;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    nxt_state = S_PREALL;
                    nxt_ref   = '0;
                    nxt_burst = imp_chg;
                end
            end
            S_PREALL: begin
                if (g_rp == ONE) begin
                    nxt_state = S_EMRS;
                end else begin
                    nxt_cnt   = g_rp - ONE;
                    nxt_state = S_RP_WAIT;
                end
            end
            S_RP_WAIT: begin
                if (cnt == ONE) nxt_state = S_EMRS;
                else            nxt_cnt   = cnt - ONE;
            end
            S_EMRS: begin
                if (g_mrd == ONE) begin
                    nxt_state = after_mrd;
                end else begin
                    nxt_cnt   = g_mrd - ONE;
                    nxt_state = S_MRD_WAIT;
                end
            end
            S_MRD_WAIT: begin
                if (cnt == ONE) nxt_state = after_mrd;
                else            nxt_cnt   = cnt - ONE;
            end
            S_AREF: begin
                nxt_ref = ref_n + RW'(1);
                if (g_ref == ONE) begin
                    nxt_state = after_ref;
                end else begin
                    nxt_cnt   = g_ref - ONE;
                    nxt_state = S_RFC_WAIT;
                end
            end
            S_RFC_WAIT: begin
                if (cnt == ONE) nxt_state = after_wait;
                else            nxt_cnt   = cnt - ONE;
            end
            default: nxt_state = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            ref_n     <= '0;
            burst_q   <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            state     <= nxt_state;
            cnt       <= nxt_cnt;
            ref_n     <= nxt_ref;
            burst_q   <= nxt_burst;
            err_pulse <= reject;
        end
    end

    // outputs decoded from the state
    always_comb begin
        cmd  = CMD_NOP;
        busy = 1'b1;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_PREALL: cmd  = CMD_PREALL;
            S_EMRS:   cmd  = CMD_EMRS;
            S_AREF:   cmd  = CMD_AREF;
            default:  cmd  = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/emrs_seq.sv
module emrs_seq
    import emrs_pkg::*;
#(
    parameter int TW       = 16,
    parameter int CW       = 8,
    parameter int AW       = 12,
    parameter int WR_MAX   = 15,
    parameter int N_AREF   = 16,
    parameter int DLL_LOCK = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          hs_map,
    input  logic [1:0]    imp_sel,
    input  logic [1:0]    term_sel,
    input  logic          dll_off,
    input  logic [TW-1:0] twr_time,
    input  logic [TW-1:0] tck_time,
    input  logic [CW-1:0] trp_cyc,
    input  logic [CW-1:0] tmrd_cyc,
    input  logic [CW-1:0] trfc_cyc,
    input  logic [CW-1:0] tko_cyc,
    input  logic          sref_exit,
    output logic [2:0]    cmd,
    output logic [1:0]    ba,
    output logic [AW-1:0] addr,
    output logic          busy,
    output logic          rd_ok,
    output logic          wr_err
);
    localparam int WRW = $clog2(WR_MAX + 1);

    logic [WRW-1:0] wr_cyc;
    logic [2:0]     wr_code;
    logic           wr_ok;
    logic           accept;
    logic           imp_chg;
    cmd_e           cmd_w;
    logic [AW-1:0]  word_d, word_q;
    logic           dll_off_q;
    logic [1:0]     last_imp;
    logic           emrs_now;

    emrs_wr_calc #(.TW(TW), .WR_MAX(WR_MAX)) u_wr (
        .twr_time (twr_time),
        .tck_time (tck_time),
        .hs_map   (hs_map),
        .wr_cyc   (wr_cyc),
        .wr_code  (wr_code),
        .wr_ok    (wr_ok)
    );

    assign imp_chg = (imp_sel != 2'd0) && (imp_sel != last_imp);

    emrs_seq_fsm #(.CW(CW), .N_AREF(N_AREF)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .wr_ok     (wr_ok),
        .imp_chg   (imp_chg),
        .trp_cyc   (trp_cyc),
        .tmrd_cyc  (tmrd_cyc),
        .trfc_cyc  (trfc_cyc),
        .tko_cyc   (tko_cyc),
        .cmd       (cmd_w),
        .busy      (busy),
        .accept    (accept),
        .err_pulse (wr_err)
    );

    always_comb begin
        word_d                       = '0;
        word_d[POS_IMP +: 2]         = imp_sel;
        word_d[POS_TERM +: 2]        = term_sel;
        word_d[POS_WR0]              = wr_code[0];
        word_d[POS_WR1]              = wr_code[1];
        word_d[POS_WR2]              = wr_code[2];
        word_d[POS_DLL]              = dll_off;
    end

    // capture the request fields on acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            dll_off_q <= 1'b0;
            last_imp  <= 2'd0;
        end else if (accept) begin
            word_q    <= word_d;
            dll_off_q <= dll_off;
            last_imp  <= imp_sel;
        end
    end

    assign emrs_now = (cmd_w == CMD_EMRS);
    assign cmd      = cmd_w;
    assign addr     = emrs_now ? word_q : '0;
    assign ba       = emrs_now ? EMR_BANK : 2'b00;

    emrs_dll_guard #(.DLL_LOCK(DLL_LOCK)) u_dll (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_evt  ((emrs_now && !dll_off_q) || sref_exit),
        .dis_evt (emrs_now && dll_off_q),
        .rd_ok   (rd_ok)
    );

endmodule

// File: rtl/emrs_seq_chk.sv
module emrs_seq_chk #(
    parameter int AW       = 12,
    parameter int DLL_LOCK = 1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd,
    input logic [1:0]    ba,
    input logic [AW-1:0] addr,
    input logic          busy,
    input logic          rd_ok,
    input logic          wr_err,
    input logic          sref_exit
);
    int since_en;
    logic en_seen;

    assign en_seen = (cmd == 3'd2 && !addr[6]) || sref_exit;

    always_ff @(posedge clk) begin
        if (!rst_n)                   since_en <= 0;
        else if (en_seen)             since_en <= 1;
        else if (since_en <= DLL_LOCK) since_en <= since_en + 1;
    end

    a_r1_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd <= 3'd3);

    a_r1_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cmd == 3'd0 && addr == '0 && ba == 2'b00));

    a_r2_preall_opens: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cmd == 3'd1);

    a_r12_preall_once: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 3'd1 |-> $rose(busy));

    a_r6_addr_only_emrs: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 3'd2 |-> addr == '0);

    a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> !busy);

    a_r9_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> since_en >= DLL_LOCK);

    a_r11_dll_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2 && addr[6]) |=> !rd_ok);

endmodule

bind emrs_seq emrs_seq_chk #(.AW(AW), .DLL_LOCK(DLL_LOCK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .ba        (ba),
    .addr      (addr),
    .busy      (busy),
    .rd_ok     (rd_ok),
    .wr_err    (wr_err),
    .sref_exit (sref_exit)
);

// File: tb/emrs_seq_bench.sv
`timescale 1ns/1ps
module emrs_seq_bench;
    localparam int TW = 16, CW = 8, AW = 12, LOCK = 50, NREF = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, req = 1'b0, hs_map = 1'b0, dll_off = 1'b0, sref_exit = 1'b0;
    logic [1:0] imp_sel = '0, term_sel = '0;
    logic [TW-1:0] twr_time = '0, tck_time = '0;
    logic [CW-1:0] trp_cyc = '0, tmrd_cyc = '0, trfc_cyc = '0, tko_cyc = '0;
    logic [2:0] cmd;
    logic [1:0] ba;
    logic [AW-1:0] addr;
    logic busy, rd_ok, wr_err;

    emrs_seq #(.TW(TW), .CW(CW), .AW(AW), .N_AREF(NREF), .DLL_LOCK(LOCK)) u_emrs_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .hs_map(hs_map), .imp_sel(imp_sel),
        .term_sel(term_sel), .dll_off(dll_off), .twr_time(twr_time), .tck_time(tck_time),
        .trp_cyc(trp_cyc), .tmrd_cyc(tmrd_cyc), .trfc_cyc(trfc_cyc), .tko_cyc(tko_cyc),
        .sref_exit(sref_exit), .cmd(cmd), .ba(ba), .addr(addr), .busy(busy),
        .rd_ok(rd_ok), .wr_err(wr_err)
    );

    typedef struct packed {
        int            t;
        logic [2:0]    c;
        logic [AW-1:0] a;
        logic [1:0]    b;
    } item_t;

    item_t exq[$];
    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    logic [1:0] exp_last = 2'd0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // monitor: every issued command is popped and compared
    always @(negedge clk) begin
        item_t it;
        string tg;
        if (rst_n && cmd != 3'd0) begin
            if (exq.size() == 0) begin
                check(1'b0, "R12", "unexpected command", int'(cmd), 0);
            end else begin
                it = exq.pop_front();
                tg = (it.c == 3'd1) ? "R2" : (it.c == 3'd2) ? "R6" : "R7";
                n_chk++;
                if (!(it.t == cyc && it.c == cmd && it.a == addr && it.b == ba)) begin
                    n_fail++;
                    $display("FAIL %s cyc/cmd/addr/ba actual %0d/%0d/%0h/%0d expected %0d/%0d/%0h/%0d",
                             tg, cyc, cmd, addr, ba, it.t, it.c, it.a, it.b);
                end
            end
        end
    end

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic run_seq(input bit hs, input logic [1:0] imp, input logic [1:0] term,
                           input bit dll, input int twr, input int tck,
                           input int rp, input int mrd, input int rfc, input int ko,
                           input bit poke, output int t_emrs);
        int wr, code, g_rp, g_mrd, g_rf, t0, t, t_end;
        bit ok, refr;
        logic [AW-1:0] w;
        @(negedge clk);
        hs_map = hs; imp_sel = imp; term_sel = term; dll_off = dll;
        twr_time = TW'(twr); tck_time = TW'(tck);
        trp_cyc = CW'(rp); tmrd_cyc = CW'(mrd); trfc_cyc = CW'(rfc); tko_cyc = CW'(ko);
        req = 1'b1;
        wr = (tck == 0) ? 0 : (twr + tck - 1) / tck;
        ok = (tck != 0) && (hs ? (wr >= 7 && wr <= 13) : (wr >= 4 && wr <= 11));
        t0 = cyc + 1;
        t_emrs = -1;
        if (!ok) begin
            @(negedge clk);
            req = 1'b0;
            check(wr_err == 1'b1, "R5", "wr_err after rejected request", int'(wr_err), 1);
            check(busy == 1'b0, "R5", "busy after rejected request", int'(busy), 0);
            @(negedge clk);
            check(wr_err == 1'b0, "R5", "wr_err one cycle only", int'(wr_err), 0);
            return;
        end
        code = hs ? wr - 7 : wr - 4;
        refr = (imp != 2'd0) && (imp != exp_last);
        exp_last = imp;
        g_rp  = (rp < 1) ? 1 : rp;
        g_mrd = (mrd < 1) ? 1 : mrd;
        g_rf  = (rfc > ko) ? rfc : ko;
        if (g_rf < 1) g_rf = 1;
        w = '0;
        w[1:0] = imp; w[3:2] = term; w[4] = code[0]; w[5] = code[1];
        w[6] = dll; w[7] = code[2];
        exq.push_back('{t: t0, c: 3'd1, a: '0, b: 2'b00});
        t_emrs = t0 + g_rp;
        exq.push_back('{t: t_emrs, c: 3'd2, a: w, b: 2'b01});
        t = t_emrs + g_mrd;
        if (refr) begin
            for (int k = 0; k < NREF; k++) begin
                exq.push_back('{t: t, c: 3'd3, a: '0, b: 2'b00});
                t = t + g_rf;
            end
        end
        t_end = t;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R3", "busy in PREALL cycle", int'(busy), 1);
        if (poke) begin
            @(negedge clk);
            req = 1'b1; term_sel = ~term; hs_map = ~hs;
            @(negedge clk);
            req = 1'b0;
        end
        wait_to(t_end - 1);
        check(busy == 1'b1, "R3", "busy before final gap ends", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b0, "R3", "busy released on time", int'(busy), 0);
        check(exq.size() == 0, "R2", "expected commands outstanding", exq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        report();
        $finish;
    end

    initial begin
        int e, c;
        repeat (3) @(negedge clk);
        check(cmd == 3'd0 && addr == '0, "R1", "cmd/addr in reset", int'(cmd), 0);
        check(busy == 1'b0 && rd_ok == 1'b0 && wr_err == 1'b0, "R1", "busy/rd_ok/wr_err in reset",
              int'({busy, rd_ok, wr_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cmd == 3'd0 && busy == 1'b0 && rd_ok == 1'b0, "R1", "idle after reset",
              int'({cmd, busy, rd_ok}), 0);

        // R4 exact ratio, R6 word, R9 read window
        run_seq(1, 2'd0, 2'd1, 0, 15000, 1250, 3, 4, 0, 0, 0, e);
        wait_to(e + LOCK - 1);
        check(rd_ok == 1'b0, "R9", "rd_ok just before lock", int'(rd_ok), 0);
        @(negedge clk);
        check(rd_ok == 1'b1, "R9", "rd_ok at lock", int'(rd_ok), 1);

        // R4 rounding up, R2 zero gaps, R9 window restart
        run_seq(0, 2'd0, 2'd2, 0, 15000, 1600, 0, 1, 0, 0, 0, e);
        wait_to(e + LOCK - 1);
        check(rd_ok == 1'b0, "R9", "rd_ok restarted low", int'(rd_ok), 0);
        @(negedge clk);
        check(rd_ok == 1'b1, "R9", "rd_ok after restart", int'(rd_ok), 1);

        // R5 range edges of both mappings
        run_seq(0, 2'd0, 2'd0, 0, 15000, 3750, 1, 2, 0, 0, 0, e);
        run_seq(1, 2'd0, 2'd3, 0, 13000, 1000, 2, 2, 0, 0, 0, e);
        run_seq(1, 2'd0, 2'd0, 0, 7000, 1000, 2, 1, 0, 0, 0, e);
        run_seq(0, 2'd0, 2'd1, 0, 11000, 1000, 1, 3, 0, 0, 0, e);
        run_seq(1, 2'd0, 2'd0, 0, 9001, 1000, 2, 2, 0, 0, 0, e);

        // R5 rejected requests
        run_seq(1, 2'd0, 2'd0, 0, 15000, 2500, 2, 2, 0, 0, 0, e);
        run_seq(0, 2'd0, 2'd0, 0, 15000, 1250, 2, 2, 0, 0, 0, e);
        run_seq(1, 2'd0, 2'd0, 0, 15000, 0, 2, 2, 0, 0, 0, e);
        run_seq(1, 2'd0, 2'd0, 0, 14001, 1000, 2, 2, 0, 0, 0, e);
        check(busy == 1'b0, "R5", "still idle after rejects", int'(busy), 0);

        // R7 refresh bursts, R8 no burst
        run_seq(1, 2'd2, 2'd1, 0, 15000, 1250, 2, 3, 5, 7, 0, e);
        run_seq(1, 2'd2, 2'd1, 0, 15000, 1250, 2, 3, 5, 7, 0, e);
        run_seq(0, 2'd3, 2'd0, 0, 15000, 1600, 3, 2, 6, 2, 0, e);
        run_seq(0, 2'd0, 2'd0, 0, 15000, 1600, 3, 2, 6, 2, 0, e);

        // R12 request during busy is ignored, fields held
        run_seq(1, 2'd0, 2'd3, 0, 15000, 1250, 4, 3, 0, 0, 1, e);

        // R11 DLL off keeps reads blocked
        wait_to(e + LOCK);
        check(rd_ok == 1'b1, "R11", "rd_ok before DLL off", int'(rd_ok), 1);
        run_seq(1, 2'd0, 2'd0, 1, 15000, 1250, 2, 2, 0, 0, 0, e);
        wait_to(e + LOCK + 3);
        check(rd_ok == 1'b0, "R11", "rd_ok with DLL off", int'(rd_ok), 0);

        // R10 self-refresh exit restarts the window
        @(negedge clk);
        sref_exit = 1'b1;
        c = cyc;
        @(negedge clk);
        sref_exit = 1'b0;
        wait_to(c + LOCK - 1);
        check(rd_ok == 1'b0, "R10", "rd_ok before lock after exit", int'(rd_ok), 0);
        @(negedge clk);
        check(rd_ok == 1'b1, "R10", "rd_ok at lock after exit", int'(rd_ok), 1);

        repeat (3) @(negedge clk);
        check(exq.size() == 0 && cmd == 3'd0, "R1", "quiet at end", exq.size(), 0);
        report();
        $finish;
    end

endmodule